// File: doc/BRIEF.md
# Clocked Synchronous Serial Transmitter

This block sends bytes over a clocked synchronous serial link: one data line plus a serial clock. Software puts a byte into a holding register with a one-cycle write strobe. The strobe clears the empty flag. When the shifter is free it copies the held byte into its shift register, raises the empty flag again, and sends the eight bits least significant bit first. Data changes on the falling edge of the serial clock, so the far end can sample on the rising edge.

The serial clock comes from one of two sources. In the first, the block makes it by dividing the system clock by a programmable period. In the second, an external clock input is passed through a two-flop synchronizer, and its edges are detected in the system clock domain. Frames run back to back when the next byte is written before the decision point. That point is the rising edge of the serial clock in the middle of bit 7. If no byte is waiting at that point, the end flag is raised. Bit 7 then finishes, the data line stays at the value of bit 7, and the serial clock rests high. Each of the two flags can drive an interrupt request through its own enable.

Top module: `sync_ser_tx`

## Requirements
- R1: While `tx_en` is 0, `tx_empty` and `tx_end` read 1, `sck_out` stays 1, no serial clock pulse is produced, and a `wr_stb` is ignored: re-enabling afterwards starts no frame. After reset both flags are 1 and `sck_out` and `txd` are 1.
- R2: The clock edge that samples `wr_stb` clears `tx_empty` and `tx_end`. From idle, the next clock edge copies the byte into the shifter and sets `tx_empty` back to 1.
- R3: With `ext_mode`=0, the serial clock period is P = max(`div_val`, 2) system clocks. Each bit has a low phase of floor(P/2) cycles and a high phase of P - floor(P/2) cycles, and a frame has exactly eight low pulses.
- R4: Bits leave on `txd` in order bit 0 to bit 7. `txd` changes only at a falling edge of `sck_out` and holds steady while `sck_out` is high.
- R5: If a byte is written before the rising edge of bit 7, the next frame follows with no gap. The high phase between bit 7 and the next bit 0 is the normal high phase.
- R6: If `tx_empty` is 1 at the rising edge of bit 7, `tx_end` becomes 1 on that edge. The frame then ends with `sck_out` high and `txd` holding the bit 7 value.
- R7: `txi_req` equals `tie` AND `tx_empty`, and `tei_req` equals `teie` AND `tx_end`.
- R8: With `ext_mode`=1, `sck_out` stays 1. Each falling edge of `sck_in` puts the next bit on `txd` no later than three system clocks after the edge. The rising edge of `sck_in` during bit 7 is the decision point.
- R9: A write sampled on the same edge as the bit 7 decision, with no byte waiting, has priority over the end flag. `tx_end` stays 0, and the new byte goes out as the following frame.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| tx_en | input | 1 | Transmit enable |
| ext_mode | input | 1 | 1 selects the external serial clock, 0 the internal divider |
| div_val | input | DIV_W | Internal serial clock period in system clocks (values below 2 act as 2) |
| tie | input | 1 | Enable for the empty interrupt request |
| teie | input | 1 | Enable for the end interrupt request |
| wr_stb | input | 1 | One-cycle write of `wr_data` into the holding register |
| wr_data | input | DATA_W | Byte to transmit |
| sck_in | input | 1 | External serial clock |
| sck_out | output | 1 | Generated serial clock, rests high |
| txd | output | 1 | Serial data |
| tx_empty | output | 1 | Holding register free |
| tx_end | output | 1 | Transmission finished |
| txi_req | output | 1 | Empty interrupt request |
| tei_req | output | 1 | End interrupt request |

## Verification
Two functions can fall in the same cycle: the software write and the shifter's bit 7 decision, which either chains a frame or ends the run. The bench counts falling edges and low-phase cycles on `sck_out`, and times `wr_stb` so that it is sampled exactly on the bit 7 rising edge. It then expects `tx_end` to stay 0 and the second byte to follow as a separate frame. A write placed well before that edge is judged by a continuous sixteen-pulse burst whose every high phase equals the computed length.

// File: rtl/sst_pkg.sv
package sst_pkg;

  typedef enum logic [1:0] {
    ST_IDLE  = 2'd0,
    ST_SHIFT = 2'd1,
    ST_DONE  = 2'd2
  } sst_state_e;

  // Serial clock period in system clocks; anything below 2 is raised to 2.
  function automatic int unsigned sst_period(input int unsigned div);
    return (div < 2) ? 2 : div;
  endfunction

  // Cycles spent low in each bit (the first half, rounded down).
  function automatic int unsigned sst_low_len(input int unsigned div);
    return sst_period(div) / 2;
  endfunction

endpackage

// File: rtl/sst_clk.sv
module sst_clk
  import sst_pkg::*;
#(
  parameter int DIV_W = 8
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             ext_mode,
  input  logic [DIV_W-1:0] div_val,
  input  logic             shifting,
  input  logic             running,
  input  logic             sck_in,
  output logic             fall_evt,
  output logic             rise_evt,
  output logic             period_end,
  output logic             sck_out
);

  logic [DIV_W-1:0] per_len;
  logic [DIV_W-1:0] low_len;
  logic [DIV_W-1:0] cnt_q;
  logic             int_fall;
  logic             int_rise;
  logic             int_wrap;
  logic             sync1_q, sync2_q, sync3_q;
  logic             ext_fall;
  logic             ext_rise;
  logic             sck_q;

  assign per_len = DIV_W'(sst_period(32'(div_val)));
  assign low_len = DIV_W'(sst_low_len(32'(div_val)));

  // Phase counter runs only while a frame (or its tail) is in progress.
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)                          cnt_q <= '0;
    else if (!running || ext_mode)       cnt_q <= '0;
    else if (cnt_q >= per_len - 1'b1)    cnt_q <= '0;
    else                                 cnt_q <= cnt_q + 1'b1;
  end

  assign int_fall = shifting && (cnt_q == '0);
  assign int_rise = running  && (cnt_q == low_len);
  assign int_wrap = running  && (cnt_q >= per_len - 1'b1);

  // Two-flop synchronizer plus a history flop for edge detection.
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      sync1_q <= 1'b1;
      sync2_q <= 1'b1;
      sync3_q <= 1'b1;
    end else begin
      sync1_q <= sck_in;
      sync2_q <= sync1_q;
      sync3_q <= sync2_q;
    end
  end

  assign ext_fall = sync3_q && !sync2_q;
  assign ext_rise = !sync3_q && sync2_q;

  assign fall_evt   = ext_mode ? (shifting && ext_fall) : int_fall;
  assign rise_evt   = ext_mode ? (shifting && ext_rise) : int_rise;
  assign period_end = ext_mode | int_wrap;

  // Generated clock: low from the falling event to the rising event.
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)                     sck_q <= 1'b1;
    else if (ext_mode || !running)  sck_q <= 1'b1;
    else if (int_fall)              sck_q <= 1'b0;
    else if (int_rise)              sck_q <= 1'b1;
  end

  assign sck_out = sck_q;

  // R3: within one low phase the counter cannot start another bit.
  a_r3_no_double_fall: assert property (@(posedge clk) disable iff (!rst_n)
    (!ext_mode && !sck_q) |-> !int_fall);

endmodule

// File: rtl/sst_shift.sv
module sst_shift
  import sst_pkg::*;
#(
  parameter int DATA_W = 8
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              tx_en,
  input  logic              empty,
  input  logic [DATA_W-1:0] hold_data,
  input  logic              fall_evt,
  input  logic              rise_evt,
  input  logic              period_end,
  output logic              shifting,
  output logic              running,
  output logic              load_evt,
  output logic              end_evt,
  output logic              txd
);

  localparam int IDX_W = (DATA_W > 1) ? $clog2(DATA_W) : 1;
  localparam logic [IDX_W-1:0] LAST_IDX = IDX_W'(DATA_W - 1);

  sst_state_e        state_q;
  logic [DATA_W-1:0] sh_q;
  logic [IDX_W-1:0]  idx_q;
  logic              bit_live_q;
  logic              txd_q;
  logic              load_idle;
  logic              last_rise;
  logic              load_chain;

  assign shifting   = (state_q == ST_SHIFT);
  assign running    = (state_q != ST_IDLE);
  assign load_idle  = tx_en && (state_q == ST_IDLE) && !empty;
  assign last_rise  = tx_en && shifting && rise_evt && bit_live_q && (idx_q == LAST_IDX);
  assign load_chain = last_rise && !empty;
  assign load_evt   = load_idle || load_chain;
  assign end_evt    = last_rise && empty;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      state_q    <= ST_IDLE;
      sh_q       <= '0;
      idx_q      <= '0;
      bit_live_q <= 1'b0;
      txd_q      <= 1'b1;
    end else if (!tx_en) begin
      state_q    <= ST_IDLE;
      idx_q      <= '0;
      bit_live_q <= 1'b0;
    end else if (load_idle) begin
      sh_q       <= hold_data;
      idx_q      <= '0;
      bit_live_q <= 1'b0;
      state_q    <= ST_SHIFT;
    end else if (shifting) begin
      if (fall_evt) begin
        txd_q      <= sh_q[idx_q];
        bit_live_q <= 1'b1;
      end else if (rise_evt && bit_live_q) begin
        bit_live_q <= 1'b0;
        if (idx_q == LAST_IDX) begin
          if (!empty) begin
            sh_q  <= hold_data;
            idx_q <= '0;
          end else begin
            state_q <= period_end ? ST_IDLE : ST_DONE;
          end
        end else begin
          idx_q <= idx_q + 1'b1;
        end
      end
    end else if (state_q == ST_DONE && period_end) begin
      state_q <= ST_IDLE;
    end
  end

  assign txd = txd_q;

  // R5: a chained load restarts at bit 0 without leaving the shift state.
  a_r5_chain_restarts: assert property (@(posedge clk) disable iff (!rst_n)
    (load_chain) |=> (idx_q == '0 && state_q != ST_DONE));

  // R6: the run can only end on the last bit of a frame.
  a_r6_end_on_last_bit: assert property (@(posedge clk) disable iff (!rst_n)
    (end_evt) |=> (state_q != ST_SHIFT || !tx_en));

endmodule

// File: rtl/sync_ser_tx.sv
module sync_ser_tx
  import sst_pkg::*;
#(
  parameter int DATA_W = 8,
  parameter int DIV_W  = 8
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              tx_en,
  input  logic              ext_mode,
  input  logic [DIV_W-1:0]  div_val,
  input  logic              tie,
  input  logic              teie,
  input  logic              wr_stb,
  input  logic [DATA_W-1:0] wr_data,
  input  logic              sck_in,
  output logic              sck_out,
  output logic              txd,
  output logic              tx_empty,
  output logic              tx_end,
  output logic              txi_req,
  output logic              tei_req
);

  logic [DATA_W-1:0] hold_q;
  logic              empty_q;
  logic              end_q;
  logic              load_evt;
  logic              end_evt;
  logic              fall_evt;
  logic              rise_evt;
  logic              period_end;
  logic              shifting;
  logic              running;

  sst_clk #(.DIV_W(DIV_W)) u_clk (
    .clk        (clk),
    .rst_n      (rst_n),
    .ext_mode   (ext_mode),
    .div_val    (div_val),
    .shifting   (shifting),
    .running    (running),
    .sck_in     (sck_in),
    .fall_evt   (fall_evt),
    .rise_evt   (rise_evt),
    .period_end (period_end),
    .sck_out    (sck_out)
  );

  sst_shift #(.DATA_W(DATA_W)) u_shift (
    .clk        (clk),
    .rst_n      (rst_n),
    .tx_en      (tx_en),
    .empty      (empty_q),
    .hold_data  (hold_q),
    .fall_evt   (fall_evt),
    .rise_evt   (rise_evt),
    .period_end (period_end),
    .shifting   (shifting),
    .running    (running),
    .load_evt   (load_evt),
    .end_evt    (end_evt),
    .txd        (txd)
  );

  // Holding register and flags; a software write outranks both shifter events.
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      hold_q  <= '0;
      empty_q <= 1'b1;
      end_q   <= 1'b1;
    end else if (!tx_en) begin
      empty_q <= 1'b1;
      end_q   <= 1'b1;
    end else if (wr_stb) begin
      hold_q  <= wr_data;
      empty_q <= 1'b0;
      end_q   <= 1'b0;
    end else begin
      if (load_evt) empty_q <= 1'b1;
      if (end_evt)  end_q   <= 1'b1;
    end
  end

  assign tx_empty = empty_q;
  assign tx_end   = end_q;
  assign txi_req  = tie  && empty_q;
  assign tei_req  = teie && end_q;

  // R1: disabling forces both flags high on the next edge.
  a_r1_disabled_flags: assert property (@(posedge clk) disable iff (!rst_n)
    (!tx_en) |=> (tx_empty && tx_end));

  // R2: a copy into the shifter refills the empty flag unless a write collides.
  a_r2_load_refills_empty: assert property (@(posedge clk) disable iff (!rst_n)
    (tx_en && load_evt && !wr_stb) |=> tx_empty);

  // R4: data only moves on a falling serial clock edge.
  a_r4_stable_while_high: assert property (@(posedge clk) disable iff (!rst_n)
    (!ext_mode && $past(!ext_mode) && sck_out && $past(sck_out)) |-> $stable(txd));

  // R6: once finished, the serial clock rests high.
  a_r6_end_parks_clock: assert property (@(posedge clk) disable iff (!rst_n)
    (tx_end) |-> sck_out);

endmodule

// File: tb/sync_ser_tx_bench.sv
`timescale 1ns/1ps
module sync_ser_tx_bench;

  logic       clk = 1'b0;
  logic       rst_n, tx_en, ext_mode, tie, teie, wr_stb, sck_in;
  logic [7:0] div_val, wr_data;
  logic       sck_out, txd, tx_empty, tx_end, txi_req, tei_req;

  always #2.5 clk = ~clk;

  sync_ser_tx u_sync_ser_tx (
    .clk(clk), .rst_n(rst_n), .tx_en(tx_en), .ext_mode(ext_mode),
    .div_val(div_val), .tie(tie), .teie(teie), .wr_stb(wr_stb),
    .wr_data(wr_data), .sck_in(sck_in), .sck_out(sck_out), .txd(txd),
    .tx_empty(tx_empty), .tx_end(tx_end), .txi_req(txi_req), .tei_req(tei_req)
  );

  int checks = 0;
  int fails  = 0;

  // Line monitor state, updated at the falling system clock edge.
  bit          mon_clr = 1'b0;
  bit          chk_high = 1'b0;
  bit          ext_flag = 1'b0;
  int          exp_low, exp_high, per;
  int          nbits, lowc, highc, err_low, err_high, err_chg, err_extlow;
  logic [15:0] cap;
  logic        prev_sck, prev_txd;

  always @(negedge clk) begin
    if (mon_clr) begin
      nbits = 0; lowc = 0; highc = 0; cap = '0;
      err_low = 0; err_high = 0; err_chg = 0; err_extlow = 0;
    end else begin
      if (sck_out && !prev_sck) begin
        if (!ext_flag && lowc != exp_low) err_low++;
        cap = {txd, cap[15:1]};
        nbits++;
        highc = 1;
      end else if (!sck_out && prev_sck) begin
        if (chk_high && nbits > 0 && highc != exp_high) err_high++;
        lowc = 1;
      end else if (sck_out) begin
        highc++;
      end else begin
        lowc++;
      end
      if (!ext_flag && sck_out && prev_sck && txd != prev_txd) err_chg++;
      if (ext_flag && !sck_out) err_extlow++;
    end
    prev_sck = sck_out;
    prev_txd = txd;
  end

  task automatic chk(input bit ok, input string req, input int act, input int exp);
    checks++;
    if (!ok) begin
      fails++;
      $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
    end
  endtask

  task automatic step();
    @(posedge clk);
    #1;
  endtask

  task automatic stepn(input int n);
    for (int i = 0; i < n; i++) step();
  endtask

  task automatic mon_reset();
    mon_clr = 1'b1;
    step();
    mon_clr = 1'b0;
  endtask

  task automatic write_byte(input logic [7:0] d);
    wr_data = d;
    wr_stb  = 1'b1;
    step();
    wr_stb  = 1'b0;
  endtask

  task automatic wait_end(input int lim);
    int n = 0;
    while (!tx_end && n < lim) begin
      step();
      n++;
    end
  endtask

  task automatic setup_int(input int div, input bit ie, input bit hi);
    per      = (div > 1) ? div : 2;
    exp_low  = per >> 1;
    exp_high = per - exp_low;
    div_val  = div[7:0];
    tie      = ie;
    teie     = ie;
    ext_mode = 1'b0;
    ext_flag = 1'b0;
    chk_high = hi;
    step();
    mon_reset();
  endtask

  task automatic run_frame(input int div, input logic [7:0] d, input bit ie);
    setup_int(div, ie, 1'b1);
    write_byte(d);
    chk(tx_empty == 1'b0 && tx_end == 1'b0, "R2 write clears flags", {tx_empty, tx_end}, 0);
    chk(txi_req == 1'b0, "R7 txi low while full", txi_req, 0);
    step();
    chk(tx_empty == 1'b1, "R2 copy refills empty", tx_empty, 1);
    chk(txi_req == ie, "R7 txi follows empty", txi_req, ie);
    wait_end(20 * per + 40);
    stepn(per + 2);
    chk(nbits == 8, "R3 eight pulses", nbits, 8);
    chk(err_low == 0, "R3 low phase length", err_low, 0);
    chk(err_high == 0, "R3 high phase length", err_high, 0);
    chk(cap[15:8] == d, "R4 lsb first order", cap[15:8], d);
    chk(err_chg == 0, "R4 data steady while high", err_chg, 0);
    chk(tx_end == 1'b1 && sck_out == 1'b1, "R6 end flag and clock high", {tx_end, sck_out}, 3);
    chk(txd == d[7], "R6 line holds bit 7", txd, d[7]);
    chk(tei_req == ie, "R7 tei follows end", tei_req, ie);
  endtask

  task automatic run_chain(input int div, input logic [7:0] a, input logic [7:0] b);
    setup_int(div, 1'b0, 1'b1);
    write_byte(a);
    step();
    write_byte(b);
    chk(tx_empty == 1'b0 && tx_end == 1'b0, "R5 second byte pending", {tx_empty, tx_end}, 0);
    wait_end(40 * per + 80);
    stepn(per + 2);
    chk(nbits == 16, "R5 sixteen pulses", nbits, 16);
    chk(cap == {b, a}, "R5 both bytes in order", cap, {b, a});
    chk(err_high == 0, "R5 no gap between frames", err_high, 0);
    chk(err_low == 0, "R3 low phase in chain", err_low, 0);
  endtask

  task automatic run_collide(input int div, input logic [7:0] a, input logic [7:0] b);
    int  falls = 0;
    int  lc    = 0;
    int  n     = 0;
    bit  pv    = 1'b1;
    setup_int(div, 1'b0, 1'b0);
    write_byte(a);
    while (!(falls == 8 && lc == exp_low) && n < 4000) begin
      step();
      n++;
      if (!sck_out && pv) begin
        falls++;
        lc = 1;
      end else if (!sck_out) begin
        lc++;
      end
      pv = sck_out;
    end
    write_byte(b);
    chk(tx_end == 1'b0, "R9 write outranks end", tx_end, 0);
    chk(sck_out == 1'b1, "R9 bit 7 rising edge", sck_out, 1);
    wait_end(40 * per + 80);
    stepn(per + 2);
    chk(nbits == 16, "R9 second frame sent", nbits, 16);
    chk(cap == {b, a}, "R9 bytes in order", cap, {b, a});
    chk(tx_end == 1'b1, "R9 end after second frame", tx_end, 1);
  endtask

  task automatic run_disabled();
    setup_int(4, 1'b0, 1'b0);
    tx_en = 1'b0;
    step();
    write_byte(8'h3C);
    stepn(30);
    chk(tx_empty == 1'b1 && tx_end == 1'b1, "R1 flags high when disabled", {tx_empty, tx_end}, 3);
    chk(sck_out == 1'b1 && nbits == 0, "R1 no clock when disabled", nbits, 0);
    tx_en = 1'b1;
    stepn(30);
    chk(nbits == 0, "R1 ignored write sends nothing", nbits, 0);
    chk(tx_empty == 1'b1 && tx_end == 1'b1, "R1 flags after re-enable", {tx_empty, tx_end}, 3);
  endtask

  task automatic run_ext(input logic [7:0] d);
    ext_mode = 1'b1;
    ext_flag = 1'b1;
    sck_in   = 1'b1;
    tie      = 1'b1;
    teie     = 1'b1;
    step();
    mon_reset();
    write_byte(d);
    stepn(3);
    chk(tx_empty == 1'b1, "R8 copied before first edge", tx_empty, 1);
    for (int i = 0; i < 8; i++) begin
      sck_in = 1'b0;
      stepn(4);
      chk(txd == d[i], "R8 bit follows sck_in fall", txd, d[i]);
      stepn(2);
      sck_in = 1'b1;
      stepn(6);
    end
    chk(tx_end == 1'b1 && tei_req == 1'b1, "R8 end after eighth rise", {tx_end, tei_req}, 3);
    chk(txd == d[7], "R6 ext line holds bit 7", txd, d[7]);
    chk(err_extlow == 0, "R8 sck_out parked high", err_extlow, 0);
    ext_mode = 1'b0;
    ext_flag = 1'b0;
  endtask

  initial begin
    repeat (150000) @(posedge clk);
    checks++;
    fails++;
    $display("FAIL watchdog R1..all actual=timeout expected=finished");
    $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
    $finish;
  end

  initial begin
    rst_n = 1'b0; tx_en = 1'b0; ext_mode = 1'b0; tie = 1'b0; teie = 1'b0;
    wr_stb = 1'b0; wr_data = '0; sck_in = 1'b1; div_val = 8'd4;
    exp_low = 2; exp_high = 2; per = 4;
    stepn(3);
    chk(tx_empty == 1'b1 && tx_end == 1'b1, "R1 reset flags", {tx_empty, tx_end}, 3);
    chk(sck_out == 1'b1 && txd == 1'b1, "R1 reset line state", {sck_out, txd}, 3);
    rst_n = 1'b1;
    tx_en = 1'b1;
    stepn(2);

    for (int dv = 0; dv < 10; dv++)
      run_frame(dv, 8'h5A ^ 8'(dv * 29), dv[0]);
    run_frame(4, 8'h80, 1'b1);
    run_frame(5, 8'h7F, 1'b0);
    run_frame(12, 8'hFF, 1'b1);

    run_chain(2, 8'hA3, 8'h4C);
    run_chain(3, 8'h01, 8'hFE);
    run_chain(6, 8'h96, 8'h69);

    run_collide(4, 8'hC3, 8'h2D);
    run_collide(5, 8'h18, 8'hE7);

    run_disabled();

    run_ext(8'hC6);
    run_ext(8'h39);

    $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
    $finish;
  end

endmodule